// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps wall-clock time and calendar date for a chip. It advances once for every pulse of a 100 Hz tick enable while its run control is set. It counts hundredths of a second, seconds, minutes and hours, and the day of month, month, two-digit year and day of week. Month lengths follow the calendar. Leap years are decided only by the year count modulo 4. Hours are kept either in 24-hour form or in 12-hour form with a PM flag.

Software reaches the block over a byte-wide register bus with an address, a read strobe, a write strobe and write data. Reading the hundredths register returns the live hundredths value. The same read freezes a copy of every other time field, so a sequence of byte reads that starts at hundredths yields one consistent time. Writing a counter register loads the counter directly in binary, whether the clock runs or not. A write-only command byte holds the run and hour-format controls.

The live value of every counter is also driven on its own output, for use by a separate time-compare block.

Top module: `tod_clock`

## Requirements
- R1: After reset, hundredths, second, minute, hour, year and weekday read 0, day and month read 1, the clock is stopped, the hour format is 24-hour and `rdata_o` is 0.
- R2: Hundredths increments by one on each clock edge at which `tick_i` is 1 and the run bit is set. With run clear, or with `tick_i` low, no counter changes.
- R3: Hundredths wraps from 99 to 0, second from 59 to 0 and minute from 59 to 0. Each wrap advances the next field. In 24-hour mode the hour wraps from 23 to 0 and ends the day.
- R4: A day ends by wrapping the day of month to 1 after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 30 in months 4, 6, 9 and 11. In any other case the day of month increments.
- R5: February ends after day 29 when year mod 4 is 0, and after day 28 otherwise.
- R6: When the month wraps from 12 to 1 the year increments. The year wraps from 99 to 0.
- R7: The weekday advances at every day end and wraps from 6 to 0.
- R8: In 12-hour mode the hour byte holds PM in bit 7 and the hour 1..12 in bits 4:0. The hour goes from 12 to 1 and from 11 to 12, and PM toggles on the 11-to-12 step. The day ends on the step from 11 PM to 12 AM (0x8B to 0x0C).
- R9: Counter bytes sit at offsets 0 hundredths, 1 hour, 2 minute, 3 second, 4 month, 5 day, 6 year and 7 weekday. A read strobe puts the addressed byte on `rdata_o` at the next clock edge, and `rdata_o` holds until the next read.
- R10: Reading offset 0 returns live hundredths and captures all other counters. Reads of offsets 1..7 return the captured values, which stay unchanged until offset 0 is read again.
- R11: A write to offsets 0..7 loads that counter with the data byte at that clock edge, whether run is set or not. The load takes priority over any advance of that counter at the same edge.
- R12: A write to offset 17 sets run from data bit 3 and 24-hour format (1) or 12-hour format (0) from data bit 2. Reads of offset 17, or of any offset above 7, return 0.
- R13: Each `cur_*_o` output shows the live value of its counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz advance enable, one cycle wide |
| addr_i | input | 5 | Register byte offset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| cur_hsec_o | output | 8 | Live hundredths |
| cur_hour_o | output | 8 | Live hour byte |
| cur_min_o | output | 8 | Live minute |
| cur_sec_o | output | 8 | Live second |
| cur_mon_o | output | 8 | Live month |
| cur_day_o | output | 8 | Live day of month |
| cur_year_o | output | 8 | Live year |
| cur_wday_o | output | 8 | Live weekday |

## Verification
The bench builds the block with its default parameters: 8-bit data, 5-bit address, hundredths limit 99 and command at offset 17. Every rollover is reached by loading counters just below their limits and then giving a single tick. The full cascade from 99 hundredths through 23:59:59 on 31 December of year 99 therefore needs one cycle of stimulus. February is tried in leap and non-leap years, and 12-hour mode is tried across the noon and midnight boundaries. A run of 100 ticks between reads exercises the snapshot.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int N_CTR    = 8;
  localparam int OFS_HSEC = 0;
  localparam int OFS_HOUR = 1;
  localparam int OFS_MIN  = 2;
  localparam int OFS_SEC  = 3;
  localparam int OFS_MON  = 4;
  localparam int OFS_DAY  = 5;
  localparam int OFS_YEAR = 6;
  localparam int OFS_WDAY = 7;

  function automatic logic [7:0] days_in_month(input logic [7:0] mon, input logic [1:0] yr_lo);
    case (mon)
      8'd2:                     days_in_month = (yr_lo == 2'd0) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  days_in_month = 8'd30;
      default:                  days_in_month = 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/tod_wrap_ctr.sv
module tod_wrap_ctr #(
  parameter int DW  = 8,
  parameter int LO  = 0,
  parameter int RST = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  input  logic [DW-1:0] lim_i,
  output logic [DW-1:0] q_o,
  output logic          carry_o
);
  logic [DW-1:0] q_q;

  assign q_o     = q_q;
  assign carry_o = inc_i && (q_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= DW'(RST);
    else if (ld_i)   q_q <= ld_val_i;
    else if (inc_i)  q_q <= (q_q >= lim_i) ? DW'(LO) : q_q + DW'(1);
  end

  // R3: a wrap lands on the low bound
  a_r3_wrap_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_o && !ld_i) |=> (q_o == DW'(LO)));
  // R2: below the limit an advance adds exactly one
  a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && (q_o < lim_i)) |=> (q_o == $past(q_o) + DW'(1)));
  // R11: a load wins over an advance
  a_r11_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (q_o == $past(ld_val_i)));
endmodule

// File: rtl/tod_hour.sv
module tod_hour #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          fmt24_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  output logic [DW-1:0] hour_o,
  output logic          day_o
);
  localparam int HMAX24 = 23;
  localparam int HMAX12 = 12;
  localparam int PM_BIT = DW - 1;

  logic [DW-1:0] q_q, nxt24, nxt12;
  logic [4:0]    h12, h12_n;
  logic          pm, pm_n;

  assign h12   = q_q[4:0];
  assign pm    = q_q[PM_BIT];
  assign h12_n = (h12 >= 5'(HMAX12)) ? 5'd1 : h12 + 5'd1;
  assign pm_n  = (h12 == 5'(HMAX12 - 1)) ? ~pm : pm;

  always_comb begin
    nxt12         = '0;
    nxt12[4:0]    = h12_n;
    nxt12[PM_BIT] = pm_n;
    nxt24         = (q_q >= DW'(HMAX24)) ? '0 : q_q + DW'(1);
  end

  // day ends at 23->0, or at 11 PM -> 12 AM
  assign day_o  = inc_i && (fmt24_i ? (q_q >= DW'(HMAX24))
                                    : (pm && h12 == 5'(HMAX12 - 1)));
  assign hour_o = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (ld_i)   q_q <= ld_val_i;
    else if (inc_i)  q_q <= fmt24_i ? nxt24 : nxt12;
  end

  a_r8_pm_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fmt24_i && inc_i && !ld_i && hour_o[4:0] == 5'd11) |=> (hour_o[PM_BIT] != $past(hour_o[PM_BIT])));
  a_r8_twelve_to_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fmt24_i && inc_i && !ld_i && hour_o[4:0] == 5'd12) |=> (hour_o[4:0] == 5'd1));
  a_r3_midnight24: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt24_i && inc_i && !ld_i && hour_o == DW'(HMAX24)) |=> (hour_o == '0));
endmodule

// File: rtl/tod_readback.sv
module tod_readback #(
  parameter int DW = 8,
  parameter int AW = 5,
  parameter int N  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [N-1:0][DW-1:0] live_i,
  output logic [DW-1:0]       rdata_o
);
  localparam int IW = $clog2(N);

  logic [N-1:0][DW-1:0] snap_q;
  logic [DW-1:0]        rdata_q;
  logic                 rd_live;

  assign rd_live = rd_i && (addr_i == '0);
  assign rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      rdata_q <= '0;
    end else if (rd_i) begin
      if (rd_live) begin
        snap_q  <= live_i;
        rdata_q <= live_i[0];
      end else if (addr_i < AW'(N)) begin
        rdata_q <= snap_q[addr_i[IW-1:0]];
      end else begin
        rdata_q <= '0;
      end
    end
  end

  // R9: read data only moves on a read strobe
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  // R10: captured time only moves on a hundredths read
  a_r10_snap_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_live |=> $stable(snap_q));
  a_r12_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i >= AW'(N)) |=> (rdata_o == '0));
endmodule

// File: rtl/tod_clock.sv
module tod_clock #(
  parameter int DW        = 8,
  parameter int AW        = 5,
  parameter int HSEC_MAX  = 99,
  parameter int SEC_MAX   = 59,
  parameter int MIN_MAX   = 59,
  parameter int MON_MAX   = 12,
  parameter int YEAR_MAX  = 99,
  parameter int WDAY_MAX  = 6,
  parameter int CMD_OFS   = 17,
  parameter int RUN_BIT   = 3,
  parameter int FMT_BIT   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] cur_hsec_o,
  output logic [DW-1:0] cur_hour_o,
  output logic [DW-1:0] cur_min_o,
  output logic [DW-1:0] cur_sec_o,
  output logic [DW-1:0] cur_mon_o,
  output logic [DW-1:0] cur_day_o,
  output logic [DW-1:0] cur_year_o,
  output logic [DW-1:0] cur_wday_o
);
  import tod_pkg::*;

  logic                    run_q, fmt24_q;
  logic [N_CTR-1:0]        ld;
  logic [N_CTR-1:0][DW-1:0] live;
  logic c_hsec, c_sec, c_min, c_day_end, c_day, c_mon, c_year, c_wday;
  logic [DW-1:0]           day_lim;

  for (genvar k = 0; k < N_CTR; k++) begin : g_ld
    assign ld[k] = wr_i && (addr_i == AW'(k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      fmt24_q <= 1'b1;
    end else if (wr_i && addr_i == AW'(CMD_OFS)) begin
      run_q   <= wdata_i[RUN_BIT];
      fmt24_q <= wdata_i[FMT_BIT];
    end
  end

  tod_wrap_ctr #(.DW(DW), .LO(0), .RST(0)) u_hsec (
    .clk_i, .rst_ni, .inc_i(run_q && tick_i), .ld_i(ld[OFS_HSEC]), .ld_val_i(wdata_i),
    .lim_i(DW'(HSEC_MAX)), .q_o(cur_hsec_o), .carry_o(c_hsec));

  tod_wrap_ctr #(.DW(DW), .LO(0), .RST(0)) u_sec (
    .clk_i, .rst_ni, .inc_i(c_hsec), .ld_i(ld[OFS_SEC]), .ld_val_i(wdata_i),
    .lim_i(DW'(SEC_MAX)), .q_o(cur_sec_o), .carry_o(c_sec));

  tod_wrap_ctr #(.DW(DW), .LO(0), .RST(0)) u_min (
    .clk_i, .rst_ni, .inc_i(c_sec), .ld_i(ld[OFS_MIN]), .ld_val_i(wdata_i),
    .lim_i(DW'(MIN_MAX)), .q_o(cur_min_o), .carry_o(c_min));

  tod_hour #(.DW(DW)) u_hour (
    .clk_i, .rst_ni, .inc_i(c_min), .fmt24_i(fmt24_q), .ld_i(ld[OFS_HOUR]),
    .ld_val_i(wdata_i), .hour_o(cur_hour_o), .day_o(c_day_end));

  assign day_lim = DW'(days_in_month(8'(cur_mon_o), cur_year_o[1:0]));

  tod_wrap_ctr #(.DW(DW), .LO(1), .RST(1)) u_day (
    .clk_i, .rst_ni, .inc_i(c_day_end), .ld_i(ld[OFS_DAY]), .ld_val_i(wdata_i),
    .lim_i(day_lim), .q_o(cur_day_o), .carry_o(c_day));

  tod_wrap_ctr #(.DW(DW), .LO(1), .RST(1)) u_mon (
    .clk_i, .rst_ni, .inc_i(c_day), .ld_i(ld[OFS_MON]), .ld_val_i(wdata_i),
    .lim_i(DW'(MON_MAX)), .q_o(cur_mon_o), .carry_o(c_mon));

  tod_wrap_ctr #(.DW(DW), .LO(0), .RST(0)) u_year (
    .clk_i, .rst_ni, .inc_i(c_mon), .ld_i(ld[OFS_YEAR]), .ld_val_i(wdata_i),
    .lim_i(DW'(YEAR_MAX)), .q_o(cur_year_o), .carry_o(c_year));

  tod_wrap_ctr #(.DW(DW), .LO(0), .RST(0)) u_wday (
    .clk_i, .rst_ni, .inc_i(c_day_end), .ld_i(ld[OFS_WDAY]), .ld_val_i(wdata_i),
    .lim_i(DW'(WDAY_MAX)), .q_o(cur_wday_o), .carry_o(c_wday));

  always_comb begin
    live           = '0;
    live[OFS_HSEC] = cur_hsec_o;
    live[OFS_HOUR] = cur_hour_o;
    live[OFS_MIN]  = cur_min_o;
    live[OFS_SEC]  = cur_sec_o;
    live[OFS_MON]  = cur_mon_o;
    live[OFS_DAY]  = cur_day_o;
    live[OFS_YEAR] = cur_year_o;
    live[OFS_WDAY] = cur_wday_o;
  end

  tod_readback #(.DW(DW), .AW(AW), .N(N_CTR)) u_rb (
    .clk_i, .rst_ni, .rd_i, .addr_i, .live_i(live), .rdata_o);

  // R2: stopped clock holds hundredths unless it is written
  a_r2_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !ld[OFS_HSEC]) |=> $stable(cur_hsec_o));
  // R6: year wrap never leaves the range
  a_r6_year_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_year && !ld[OFS_YEAR]) |=> (cur_year_o == '0));
  // R7: weekday wrap returns to 0
  a_r7_wday_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_wday && !ld[OFS_WDAY]) |=> (cur_wday_o == '0));
  // R5: day wrap steps the month
  a_r5_month_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_day && !ld[OFS_DAY] && !ld[OFS_MON] && cur_mon_o < DW'(MON_MAX)) |=> (cur_day_o == DW'(1)) && (cur_mon_o == $past(cur_mon_o) + DW'(1)));
endmodule

// File: tb/sim_tod_clock.sv
module sim_tod_clock;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic       rd_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, cur_hsec_o, cur_hour_o, cur_min_o, cur_sec_o;
  logic [7:0] cur_mon_o, cur_day_o, cur_year_o, cur_wday_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  tod_clock u0 (.*);

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr_reg(int a, logic [7:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = 5'(a); wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd_reg(int a, output logic [7:0] d);
    @(negedge clk_i); rd_i = 1'b1; addr_i = 5'(a);
    @(negedge clk_i); rd_i = 1'b0; d = rdata_o;
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic set_time(logic [7:0] hs, s, m, h, d, mo, y, w);
    wr_reg(0, hs); wr_reg(3, s); wr_reg(2, m); wr_reg(1, h);
    wr_reg(5, d);  wr_reg(4, mo); wr_reg(6, y); wr_reg(7, w);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 rdata", rdata_o, 8'h00);
    rd_reg(0, v); check("R1 hsec", v, 0);
    rd_reg(1, v); check("R1 hour", v, 0);
    rd_reg(2, v); check("R1 min", v, 0);
    rd_reg(3, v); check("R1 sec", v, 0);
    rd_reg(4, v); check("R1 month", v, 1);
    rd_reg(5, v); check("R1 day", v, 1);
    rd_reg(6, v); check("R1 year", v, 0);
    rd_reg(7, v); check("R1 wday", v, 0);
    rd_reg(17, v); check("R12 cmd read zero", v, 0);
    rd_reg(9, v); check("R12 unmapped read zero", v, 0);
  endtask

  task automatic t_stopped();
    logic [7:0] v;
    tick_n(3);
    check("R2 stopped no advance", cur_hsec_o, 0);
    set_time(10, 20, 30, 15, 25, 6, 7, 3);
    check("R11 load while stopped", cur_hsec_o, 10);
    check("R13 live day", cur_day_o, 25);
    rd_reg(0, v); check("R9 ofs0 hsec", v, 10);
    rd_reg(1, v); check("R9 ofs1 hour", v, 15);
    rd_reg(2, v); check("R9 ofs2 min", v, 30);
    rd_reg(3, v); check("R9 ofs3 sec", v, 20);
    rd_reg(4, v); check("R9 ofs4 month", v, 6);
    rd_reg(5, v); check("R9 ofs5 day", v, 25);
    rd_reg(6, v); check("R9 ofs6 year", v, 7);
    rd_reg(7, v); check("R9 ofs7 wday", v, 3);
    @(negedge clk_i);
    check("R9 rdata holds", rdata_o, 3);
  endtask

  task automatic t_run();
    wr_reg(17, 8'h0C);
    wr_reg(0, 10);
    tick_n(5);
    check("R2 five ticks", cur_hsec_o, 15);
    repeat (4) @(negedge clk_i);
    check("R2 no tick no advance", cur_hsec_o, 15);
    set_time(99, 58, 10, 5, 9, 9, 9, 1);
    tick_n(1);
    check("R3 hsec wrap", cur_hsec_o, 0);
    check("R3 sec carry", cur_sec_o, 59);
    check("R3 min untouched", cur_min_o, 10);
  endtask

  task automatic t_cascade();
    set_time(99, 59, 59, 23, 31, 12, 99, 6);
    tick_n(1);
    check("R3 full hsec", cur_hsec_o, 0);
    check("R3 full sec", cur_sec_o, 0);
    check("R3 full min", cur_min_o, 0);
    check("R3 full hour", cur_hour_o, 0);
    check("R4 dec31 day", cur_day_o, 1);
    check("R6 month wrap", cur_mon_o, 1);
    check("R6 year wrap", cur_year_o, 0);
    check("R7 wday wrap", cur_wday_o, 0);
    set_time(99, 59, 59, 23, 31, 12, 41, 2);
    tick_n(1);
    check("R6 year inc", cur_year_o, 42);
    check("R7 wday inc", cur_wday_o, 3);
  endtask

  task automatic end_day(string req, logic [7:0] d, mo, y, exp_d, exp_mo);
    set_time(99, 59, 59, 23, d, mo, y, 0);
    tick_n(1);
    check({req, " day"}, cur_day_o, exp_d);
    check({req, " month"}, cur_mon_o, exp_mo);
  endtask

  task automatic t_months();
    end_day("R4 apr30", 30, 4, 1, 1, 5);
    end_day("R4 nov30", 30, 11, 1, 1, 12);
    end_day("R4 jan30", 30, 1, 1, 31, 1);
    end_day("R4 aug31", 31, 8, 1, 1, 9);
    end_day("R5 leap feb28", 28, 2, 4, 29, 2);
    end_day("R5 leap feb29", 29, 2, 8, 1, 3);
    end_day("R5 plain feb28", 28, 2, 5, 1, 3);
    end_day("R5 year0 feb28", 28, 2, 0, 29, 2);
  endtask

  task automatic t_12h();
    wr_reg(17, 8'h08);
    set_time(99, 59, 59, 8'h0B, 5, 3, 1, 2);
    tick_n(1);
    check("R8 11am to 12pm", cur_hour_o, 8'h8C);
    check("R8 noon keeps day", cur_day_o, 5);
    set_time(99, 59, 59, 8'h8C, 5, 3, 1, 2);
    tick_n(1);
    check("R8 12pm to 1pm", cur_hour_o, 8'h81);
    set_time(99, 59, 59, 8'h8B, 5, 3, 1, 2);
    tick_n(1);
    check("R8 11pm to 12am", cur_hour_o, 8'h0C);
    check("R8 midnight day", cur_day_o, 6);
    check("R8 midnight wday", cur_wday_o, 3);
    set_time(99, 59, 59, 8'h0C, 5, 3, 1, 2);
    tick_n(1);
    check("R8 12am to 1am", cur_hour_o, 8'h01);
    wr_reg(17, 8'h04);
    set_time(99, 59, 59, 23, 5, 3, 1, 2);
    tick_n(2);
    check("R12 stop holds hour", cur_hour_o, 23);
    check("R12 stop holds hsec", cur_hsec_o, 99);
  endtask

  task automatic t_snapshot();
    logic [7:0] v;
    wr_reg(17, 8'h0C);
    set_time(0, 10, 4, 3, 2, 1, 0, 0);
    rd_reg(0, v); check("R10 live hsec", v, 0);
    tick_n(100);
    check("R13 live sec", cur_sec_o, 11);
    rd_reg(3, v); check("R10 frozen sec", v, 10);
    rd_reg(3, v); check("R10 frozen sec again", v, 10);
    rd_reg(0, v); check("R10 hsec after 100", v, 0);
    rd_reg(3, v); check("R10 refreshed sec", v, 11);
    rd_reg(2, v); check("R10 refreshed min", v, 4);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_stopped();
    t_run();
    t_cascade();
    t_months();
    t_12h();
    t_snapshot();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule